// File: doc/BRIEF.md
# Task Context Validity Checker

This block screens the context of an incoming task before a hardware task switch commits it. The switch logic holds the new context on the inputs and pulses `start`. The block then walks a fixed chain of checks, one per clock. The chain covers the size of the task record, the local descriptor table selector, and the stack, code and four data segment selectors together with their descriptor attributes.

The walk stops at the first rule that is broken and reports fault vector 10. It also reports an error code built from the offending selector and an external-event flag. If every rule holds, the block reports a clean pass with vector 0.

The surrounding logic must hold all context inputs stable from the accepted start until `done`. The results stay on the outputs until the next accepted start.

Top module: `task_ctx_validator`

## Requirements
- R1: A start pulse is accepted only while `busy` is low, and `busy` rises in the next cycle. A start pulse while `busy` is high has no effect on the walk, its timing or its result, including the external-event bit. All outputs are 0 after reset.
- R2: The checks run one per clock in this order: record size (check 0), local table (check 1), then the six segments stored in the flat ports as slot 0 = stack, slot 1 = code, slots 2..5 = four data segments (checks 2..7). If check k is the first to fail, `done` is high in the (k+2)-th cycle after the start edge. A clean pass raises `done` in the 9th cycle. `done` lasts exactly one cycle and is never high together with `busy`.
- R3: A task record limit below 103 is a fault whose error code carries `ctx_sel`. A limit of exactly 103 passes.
- R4: A local table selector with bits 15:2 all zero passes regardless of its attributes. Any other local table selector faults with that selector if any of the following holds: bit 2 (table indicator) is set, the selector lies beyond its table limit, the descriptor is not of the local-table type, or the descriptor is not present. A selector lies beyond its table limit when {sel[15:3],3'b111} is greater than the limit.
- R5: The stack selector faults under any of these conditions: it is null (bits 15:2 zero), it lies beyond its table limit, its descriptor is a code segment, its descriptor is not writable, its descriptor privilege differs from `new_priv`, or its requested privilege (selector bits 1:0) differs from `new_priv`.
- R6: The code selector faults if it is null, lies beyond its table limit, or its descriptor is not a code segment.
- R7: For the code segment, a non-conforming descriptor faults when its privilege differs from `new_priv`. A conforming descriptor faults only when its privilege is numerically greater than `new_priv`.
- R8: A data selector that is null is skipped. A non-null data selector faults if it lies beyond its table limit, or if it names a code segment whose read bit is 0. A non-code descriptor always counts as readable.
- R9: On a fault, `err_code` is {sel[15:3], sel[2], 1'b0, ext}. Here sel is the offending selector and ext is `ext_event` as sampled with the accepted start.
- R10: With `done`, `fault` is high and `vector` is 10 on a fault; on a pass, `fault`, `vector` and `err_code` are 0. These outputs keep their values until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a validation walk |
| ext_event | input | 1 | Switch caused by an external event, sampled at start |
| new_priv | input | 2 | Privilege level of the incoming task |
| ctx_sel | input | 16 | Selector of the new task record |
| ctx_limit | input | 32 | Limit of the new task record descriptor |
| ltab_sel | input | 16 | Local descriptor table selector |
| ltab_tlim | input | 16 | Limit of the table the local table selector indexes |
| ltab_is_ltab | input | 1 | Descriptor is of the local-table type |
| ltab_present | input | 1 | Local table descriptor present bit |
| seg_sel | input | 96 | Six segment selectors, slot i at bits i*16 +: 16 |
| seg_tlim | input | 96 | Table limit for each segment selector |
| seg_code | input | 6 | Descriptor is a code segment, one bit per slot |
| seg_conf | input | 6 | Code descriptor is conforming |
| seg_rw | input | 6 | Writable (data) or readable (code) bit |
| seg_dpl | input | 12 | Descriptor privilege, slot i at bits i*2 +: 2 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| fault | output | 1 | The walk found a violation |
| vector | output | 8 | 10 on a fault, otherwise 0 |
| err_code | output | 16 | Offending selector with external-event bit |

## Verification
The assertions check on every cycle the following properties:
- the start-to-busy handshake
- the single-cycle `done` pulse and its exclusion with `busy`
- the bound on walk length
- the short-record fault landing two cycles after start
- the cleared bit 1 and the latched external bit of the error code
- the vector value
- the hold of results while idle

Which rule fails first, and whether the walk stops at the right step, depend on the contents of the context. Only the bench scenarios can show these, by comparing the cycle of `done` and the error code with a model. The same applies to the boundary cases: a limit of exactly 103, a selector whose last byte sits on the table limit, and conforming privilege equal to or below the task's.

// File: rtl/tcv_pkg.sv
package tcv_pkg;
  localparam int SEL_W = 16;
  localparam int VEC_W = 8;
  localparam int unsigned FAULT_VECTOR = 10;

  typedef enum logic [1:0] {
    SEG_STACK = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_DATA  = 2'd2
  } seg_kind_e;

  // Error word: index and table indicator kept, bit 1 cleared, bit 0 = external flag.
  function automatic logic [SEL_W-1:0] make_err(input logic [SEL_W-1:0] sel, input logic ext);
    return {sel[SEL_W-1:2], 1'b0, ext};
  endfunction

  // True when the last byte of the referenced descriptor lies past the table limit.
  function automatic logic past_limit(input logic [SEL_W-1:0] sel, input logic [SEL_W-1:0] tlim);
    return {sel[SEL_W-1:3], 3'b111} > tlim;
  endfunction
endpackage

// File: rtl/tcv_seg_rule.sv
module tcv_seg_rule
  import tcv_pkg::*;
#(
  parameter seg_kind_e KIND   = SEG_DATA,
  parameter int        PRIV_W = 2
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [SEL_W-1:0]  tlim,
  input  logic              is_code,
  input  logic              is_conf,
  input  logic              rw,
  input  logic [PRIV_W-1:0] dpl,
  input  logic [PRIV_W-1:0] new_priv,
  output logic              bad
);
  logic null_sel;
  logic beyond;
  logic priv_mismatch;
  logic stack_bad;
  logic code_bad;
  logic data_bad;

  assign null_sel      = (sel[SEL_W-1:2] == '0);
  assign beyond        = past_limit(sel, tlim);
  assign priv_mismatch = (dpl != new_priv);

  // Stack: must be a writable data segment at exactly the new privilege.
  assign stack_bad = null_sel | beyond | is_code | !rw | priv_mismatch
                   | (sel[PRIV_W-1:0] != new_priv);

  // Code: conforming allows a more privileged descriptor, non-conforming needs equality.
  assign code_bad = null_sel | beyond | !is_code
                  | (is_conf ? (dpl > new_priv) : priv_mismatch);

  // Data: null skipped; code descriptors must carry the read bit.
  assign data_bad = !null_sel & (beyond | (is_code & !rw));

  always_comb begin
    unique case (KIND)
      SEG_STACK: bad = stack_bad;
      SEG_CODE:  bad = code_bad;
      default:   bad = data_bad;
    endcase
  end
endmodule

// File: rtl/tcv_rule_bank.sv
module tcv_rule_bank
  import tcv_pkg::*;
#(
  parameter int NSEG          = 6,
  parameter int PRIV_W        = 2,
  parameter int LIM_W         = 32,
  parameter int MIN_CTX_LIMIT = 103,
  localparam int NSTEP        = NSEG + 2
) (
  input  logic [PRIV_W-1:0]      new_priv,
  input  logic [SEL_W-1:0]       ctx_sel,
  input  logic [LIM_W-1:0]       ctx_limit,
  input  logic [SEL_W-1:0]       ltab_sel,
  input  logic [SEL_W-1:0]       ltab_tlim,
  input  logic                   ltab_is_ltab,
  input  logic                   ltab_present,
  input  logic [NSEG*SEL_W-1:0]  seg_sel,
  input  logic [NSEG*SEL_W-1:0]  seg_tlim,
  input  logic [NSEG-1:0]        seg_code,
  input  logic [NSEG-1:0]        seg_conf,
  input  logic [NSEG-1:0]        seg_rw,
  input  logic [NSEG*PRIV_W-1:0] seg_dpl,
  output logic [NSTEP-1:0]       fail,
  output logic [NSTEP*SEL_W-1:0] sel_flat
);
  logic ltab_null;

  assign ltab_null = (ltab_sel[SEL_W-1:2] == '0);

  assign fail[0] = (ctx_limit < LIM_W'(MIN_CTX_LIMIT));
  assign fail[1] = !ltab_null & (ltab_sel[2] | past_limit(ltab_sel, ltab_tlim)
                               | !ltab_is_ltab | !ltab_present);

  assign sel_flat[0 +: SEL_W]     = ctx_sel;
  assign sel_flat[SEL_W +: SEL_W] = ltab_sel;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam seg_kind_e KIND = seg_kind_e'((i == 0) ? SEG_STACK :
                                             (i == 1) ? SEG_CODE : SEG_DATA);
    tcv_seg_rule #(
      .KIND   (KIND),
      .PRIV_W (PRIV_W)
    ) u_rule (
      .sel      (seg_sel[i*SEL_W +: SEL_W]),
      .tlim     (seg_tlim[i*SEL_W +: SEL_W]),
      .is_code  (seg_code[i]),
      .is_conf  (seg_conf[i]),
      .rw       (seg_rw[i]),
      .dpl      (seg_dpl[i*PRIV_W +: PRIV_W]),
      .new_priv (new_priv),
      .bad      (fail[i+2])
    );
    assign sel_flat[(i+2)*SEL_W +: SEL_W] = seg_sel[i*SEL_W +: SEL_W];
  end
endmodule

// File: rtl/tcv_walker.sv
module tcv_walker
  import tcv_pkg::*;
#(
  parameter int  NSTEP = 8,
  localparam int IW    = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   ext_in,
  input  logic [NSTEP-1:0]       fail,
  input  logic [NSTEP*SEL_W-1:0] sel_flat,
  output logic                   busy,
  output logic                   done,
  output logic                   fault,
  output logic [VEC_W-1:0]       vector,
  output logic [SEL_W-1:0]       err_code
);
  logic [IW-1:0]    step;
  logic             ext_q;
  logic             cur_fail;
  logic             last;
  logic [SEL_W-1:0] cur_sel;

  assign cur_fail = fail[step];
  assign cur_sel  = sel_flat[step*SEL_W +: SEL_W];
  assign last     = (step == IW'(NSTEP-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      fault    <= 1'b0;
      vector   <= '0;
      err_code <= '0;
      step     <= '0;
      ext_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          step     <= '0;
          ext_q    <= ext_in;
          fault    <= 1'b0;
          vector   <= '0;
          err_code <= '0;
        end
      end else if (cur_fail || last) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        fault <= cur_fail;
        if (cur_fail) begin
          vector   <= VEC_W'(FAULT_VECTOR);
          err_code <= make_err(cur_sel, ext_q);
        end
      end else begin
        step <= step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/task_ctx_validator.sv
module task_ctx_validator
  import tcv_pkg::*;
#(
  parameter int  NSEG          = 6,
  parameter int  PRIV_W        = 2,
  parameter int  LIM_W         = 32,
  parameter int  MIN_CTX_LIMIT = 103,
  localparam int NSTEP         = NSEG + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   ext_event,
  input  logic [PRIV_W-1:0]      new_priv,
  input  logic [SEL_W-1:0]       ctx_sel,
  input  logic [LIM_W-1:0]       ctx_limit,
  input  logic [SEL_W-1:0]       ltab_sel,
  input  logic [SEL_W-1:0]       ltab_tlim,
  input  logic                   ltab_is_ltab,
  input  logic                   ltab_present,
  input  logic [NSEG*SEL_W-1:0]  seg_sel,
  input  logic [NSEG*SEL_W-1:0]  seg_tlim,
  input  logic [NSEG-1:0]        seg_code,
  input  logic [NSEG-1:0]        seg_conf,
  input  logic [NSEG-1:0]        seg_rw,
  input  logic [NSEG*PRIV_W-1:0] seg_dpl,
  output logic                   busy,
  output logic                   done,
  output logic                   fault,
  output logic [VEC_W-1:0]       vector,
  output logic [SEL_W-1:0]       err_code
);
  logic [NSTEP-1:0]       fail;
  logic [NSTEP*SEL_W-1:0] sel_flat;

  tcv_rule_bank #(
    .NSEG          (NSEG),
    .PRIV_W        (PRIV_W),
    .LIM_W         (LIM_W),
    .MIN_CTX_LIMIT (MIN_CTX_LIMIT)
  ) u_rules (
    .new_priv     (new_priv),
    .ctx_sel      (ctx_sel),
    .ctx_limit    (ctx_limit),
    .ltab_sel     (ltab_sel),
    .ltab_tlim    (ltab_tlim),
    .ltab_is_ltab (ltab_is_ltab),
    .ltab_present (ltab_present),
    .seg_sel      (seg_sel),
    .seg_tlim     (seg_tlim),
    .seg_code     (seg_code),
    .seg_conf     (seg_conf),
    .seg_rw       (seg_rw),
    .seg_dpl      (seg_dpl),
    .fail         (fail),
    .sel_flat     (sel_flat)
  );

  tcv_walker #(
    .NSTEP (NSTEP)
  ) u_walk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .ext_in   (ext_event),
    .fail     (fail),
    .sel_flat (sel_flat),
    .busy     (busy),
    .done     (done),
    .fault    (fault),
    .vector   (vector),
    .err_code (err_code)
  );
endmodule

// File: rtl/tcv_checker.sv
module tcv_checker
  import tcv_pkg::*;
#(
  parameter int LIM_W         = 32,
  parameter int MIN_CTX_LIMIT = 103,
  parameter int NSTEP         = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             ext_event,
  input logic [SEL_W-1:0] ctx_sel,
  input logic [LIM_W-1:0] ctx_limit,
  input logic             busy,
  input logic             done,
  input logic             fault,
  input logic [VEC_W-1:0] vector,
  input logic [SEL_W-1:0] err_code
);
  logic        ext_lat;
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_lat <= 1'b0;
      run_len <= 0;
    end else begin
      if (start && !busy) ext_lat <= ext_event;
      run_len <= busy ? run_len + 1 : 0;
    end
  end

  a_r1_start_busy: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy);

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r2_walk_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> run_len < NSTEP);

  a_r3_short_ctx: assert property (@(posedge clk) disable iff (rst)
    start && !busy && (ctx_limit < LIM_W'(MIN_CTX_LIMIT))
      |-> ##2 (done && fault && err_code[SEL_W-1:2] == $past(ctx_sel[SEL_W-1:2], 2)));

  a_r9_bit1_clear: assert property (@(posedge clk) disable iff (rst)
    fault |-> !err_code[1]);

  a_r9_ext_bit: assert property (@(posedge clk) disable iff (rst)
    done && fault |-> err_code[0] == ext_lat);

  a_r10_vector: assert property (@(posedge clk) disable iff (rst)
    done |-> vector == (fault ? VEC_W'(FAULT_VECTOR) : VEC_W'(0)));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> $stable(fault) && $stable(vector) && $stable(err_code));
endmodule

bind task_ctx_validator tcv_checker #(
  .LIM_W         (LIM_W),
  .MIN_CTX_LIMIT (MIN_CTX_LIMIT),
  .NSTEP         (NSTEP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .ext_event (ext_event),
  .ctx_sel   (ctx_sel),
  .ctx_limit (ctx_limit),
  .busy      (busy),
  .done      (done),
  .fault     (fault),
  .vector    (vector),
  .err_code  (err_code)
);

// File: tb/task_ctx_validator_tb.sv
module task_ctx_validator_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        ext_event = 1'b0;
  logic [1:0]  new_priv;
  logic [15:0] ctx_sel;
  logic [31:0] ctx_limit;
  logic [15:0] ltab_sel, ltab_tlim;
  logic        ltab_is_ltab, ltab_present;
  logic [15:0] s_sel [6];
  logic [15:0] s_tlim [6];
  logic        s_code [6];
  logic        s_conf [6];
  logic        s_rw [6];
  logic [1:0]  s_dpl [6];
  logic [95:0] seg_sel, seg_tlim;
  logic [5:0]  seg_code, seg_conf, seg_rw;
  logic [11:0] seg_dpl;
  logic        busy, done, fault;
  logic [7:0]  vector;
  logic [15:0] err_code;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < 6; i++) begin
      seg_sel[i*16 +: 16]  = s_sel[i];
      seg_tlim[i*16 +: 16] = s_tlim[i];
      seg_code[i]          = s_code[i];
      seg_conf[i]          = s_conf[i];
      seg_rw[i]            = s_rw[i];
      seg_dpl[i*2 +: 2]    = s_dpl[i];
    end
  end

  task_ctx_validator u_dut (
    .clk(clk), .rst(rst), .start(start), .ext_event(ext_event), .new_priv(new_priv),
    .ctx_sel(ctx_sel), .ctx_limit(ctx_limit), .ltab_sel(ltab_sel), .ltab_tlim(ltab_tlim),
    .ltab_is_ltab(ltab_is_ltab), .ltab_present(ltab_present), .seg_sel(seg_sel),
    .seg_tlim(seg_tlim), .seg_code(seg_code), .seg_conf(seg_conf), .seg_rw(seg_rw),
    .seg_dpl(seg_dpl), .busy(busy), .done(done), .fault(fault), .vector(vector),
    .err_code(err_code)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic bit over(input logic [15:0] s, input logic [15:0] t);
    return (int'(s >> 3) * 8 + 7) > int'(t);
  endfunction

  function automatic bit seg_bad(input int i);
    bit is_null = (s_sel[i] >> 2) == 0;
    if (i == 0)
      return is_null || over(s_sel[i], s_tlim[i]) || s_code[i] || !s_rw[i] ||
             s_dpl[i] != new_priv || s_sel[i][1:0] != new_priv;
    if (i == 1) begin
      if (is_null || over(s_sel[i], s_tlim[i]) || !s_code[i]) return 1;
      if (s_conf[i]) return s_dpl[i] > new_priv;
      return s_dpl[i] != new_priv;
    end
    if (is_null) return 0;
    return over(s_sel[i], s_tlim[i]) || (s_code[i] && !s_rw[i]);
  endfunction

  function automatic int first_bad();
    if (ctx_limit < 103) return 0;
    if ((ltab_sel >> 2) != 0 &&
        (ltab_sel[2] || over(ltab_sel, ltab_tlim) || !ltab_is_ltab || !ltab_present))
      return 1;
    for (int i = 0; i < 6; i++) if (seg_bad(i)) return i + 2;
    return 8;
  endfunction

  function automatic logic [15:0] sel_of(input int idx);
    if (idx == 0) return ctx_sel;
    if (idx == 1) return ltab_sel;
    return s_sel[idx-2];
  endfunction

  // ---------------- stimulus ----------------
  task automatic set_good();
    new_priv = 2'd2; ctx_sel = 16'h0028; ctx_limit = 32'd200;
    ltab_sel = 16'h0030; ltab_tlim = 16'hFFFF; ltab_is_ltab = 1; ltab_present = 1;
    ext_event = 0;
    for (int i = 0; i < 6; i++) begin
      s_sel[i] = 16'h0040 + 16'(i * 8); s_tlim[i] = 16'hFFFF;
      s_code[i] = 0; s_conf[i] = 0; s_rw[i] = 1; s_dpl[i] = 2'd2;
    end
    s_sel[0] = 16'h0042;            // stack requested privilege = 2
    s_code[1] = 1;
  endtask

  function automatic bit rare();
    return $urandom_range(0, 13) == 0;
  endfunction

  task automatic set_rand();
    new_priv  = 2'($urandom_range(0, 3));
    ext_event = 1'($urandom_range(0, 1));
    ctx_sel   = 16'($urandom) & 16'hFFFC;
    ctx_limit = rare() ? $urandom_range(95, 110) : $urandom_range(103, 5000);
    ltab_sel  = rare() ? 16'($urandom) : {13'($urandom_range(0, 300)), 3'b000};
    ltab_tlim = rare() ? 16'($urandom_range(0, 2500)) : 16'hFFFF;
    ltab_is_ltab = !rare(); ltab_present = !rare();
    for (int i = 0; i < 6; i++) begin
      s_sel[i]  = {13'($urandom_range(1, 400)), 1'b0, new_priv};
      s_tlim[i] = rare() ? 16'($urandom_range(0, 3500)) : 16'hFFFF;
      s_rw[i]   = !rare();
      s_conf[i] = 1'($urandom_range(0, 1));
      s_dpl[i]  = new_priv;
      s_code[i] = 0;
    end
    if (rare()) s_sel[0][1:0] = 2'($urandom);
    if (rare()) s_dpl[0] = 2'($urandom);
    s_code[0] = rare();
    s_code[1] = !rare();
    s_dpl[1]  = s_conf[1] ? 2'($urandom_range(0, int'(new_priv))) : new_priv;
    if (rare()) s_dpl[1] = 2'($urandom);
    for (int i = 2; i < 6; i++) begin
      s_code[i] = 1'($urandom_range(0, 1));
      if (rare()) s_sel[i] = 16'($urandom_range(0, 3));
    end
    if (rare()) s_sel[$urandom_range(0, 1)] = 16'($urandom_range(0, 3));
  endtask

  // Launch one walk and compare timing and results with the model.
  task automatic run_case(input string req, input bit poke);
    int exp_idx = first_bad();
    int stop    = (exp_idx == 8) ? 7 : exp_idx;
    logic [15:0] exp_err;
    int cnt;
    exp_err = (exp_idx == 8) ? 16'h0 : {sel_of(exp_idx)[15:2], 1'b0, ext_event};
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; cnt = 1;
    chk(req, "busy after start (R1)", busy, 1);
    chk(req, "fault cleared by start (R10)", fault, 0);
    while (!done && cnt < 20) begin
      if (poke && cnt == 2) begin start = 1; ext_event = ~ext_event; end
      else start = 0;
      @(negedge clk); cnt++;
    end
    start = 0;
    chk(req, "done cycle (R2)", cnt, stop + 2);
    chk(req, "fault (R10)", fault, exp_idx != 8);
    chk(req, "vector (R10)", vector, (exp_idx != 8) ? 10 : 0);
    chk(req, "err_code (R9)", err_code, exp_err);
    @(negedge clk);
    chk(req, "done one cycle (R2)", done, 0);
    chk(req, "err_code held (R10)", err_code, exp_err);
    chk(req, "fault held (R10)", fault, exp_idx != 8);
  endtask

  initial begin
    void'($urandom(32'd4242));
    set_good();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "busy reset", busy, 0);
    chk("R1", "done reset", done, 0);
    chk("R1", "fault reset", fault, 0);
    chk("R1", "err reset", {vector, err_code}, 0);

    set_good(); run_case("R2", 0);                              // clean pass, done in cycle 9
    set_good(); ctx_limit = 102; ext_event = 1; run_case("R3", 0);  // err 0x0029
    set_good(); ctx_limit = 103; run_case("R3", 0);             // boundary passes
    set_good(); ltab_sel = 16'h0034; run_case("R4", 0);         // table indicator set
    set_good(); ltab_sel = 16'h0000; ltab_is_ltab = 0; ltab_present = 0; run_case("R4", 0);
    set_good(); ltab_tlim = 16'h0037; run_case("R4", 0);        // last byte on limit: pass
    set_good(); ltab_tlim = 16'h0036; run_case("R4", 0);        // one past: fault
    set_good(); ltab_present = 0; run_case("R4", 0);
    set_good(); s_sel[0] = 16'h0000; run_case("R5", 0);         // null stack
    set_good(); s_sel[0] = 16'h0041; run_case("R5", 0);         // requested privilege mismatch
    set_good(); s_dpl[0] = 2'd1; run_case("R5", 0);
    set_good(); s_rw[0] = 0; run_case("R5", 0);
    set_good(); s_code[0] = 1; s_rw[0] = 1; run_case("R5", 0);
    set_good(); s_code[1] = 0; run_case("R6", 0);
    set_good(); s_sel[1] = 16'h0003; run_case("R6", 0);         // null code selector
    set_good(); s_conf[1] = 1; s_dpl[1] = 2'd1; run_case("R7", 0);  // conforming, lower: pass
    set_good(); s_conf[1] = 1; s_dpl[1] = 2'd3; run_case("R7", 0);  // conforming, higher: fault
    set_good(); s_dpl[1] = 2'd1; run_case("R7", 0);             // non-conforming mismatch
    set_good(); s_sel[2] = 16'h0000; s_tlim[2] = 16'h0000; run_case("R8", 0);  // null skipped
    set_good(); s_code[3] = 1; s_rw[3] = 0; ext_event = 1; run_case("R8", 0);
    set_good(); s_code[4] = 1; s_rw[4] = 1; run_case("R8", 0);  // readable code: pass
    set_good(); s_rw[5] = 0; s_tlim[5] = 16'h0010; run_case("R8", 0);
    // R1: start during a walk is ignored, ext toggled meanwhile
    set_good(); s_code[5] = 1; s_rw[5] = 0; run_case("R1", 1);
    // R9: error code keeps table indicator, drops requested privilege bits
    set_good(); s_sel[2] = 16'h1237; s_tlim[2] = 16'h0100; ext_event = 1; run_case("R9", 0);

    for (int n = 0; n < 400; n++) begin
      set_rand();
      run_case("R2", 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule